// File: doc/BRIEF.md
# Overflow-Safe Magnitude Comparator

This block compares two operands of a parameterised width and reports whether the first is greater than, less than or equal to the second. It is purely combinational. A single select input chooses how the operands are read: as two's complement signed values or as unsigned values. Only one subtractor is used. It forms `op_a + ~op_b + 1`, and the three flags are then derived from that difference.

A raw sign test on the difference gives the wrong answer when the subtraction wraps around. In signed mode the block therefore takes the sign of the difference XOR-ed with the signed overflow of the subtraction. In unsigned mode the "less than" answer is the borrow out of the subtractor, which is the inverted carry out. A subtract overflow flag is brought out so that the wrap condition can be observed.

The signed range is -2^(W-1) to 2^(W-1)-1. The unsigned range is 0 to 2^W-1. The subtractor is built from small carry-lookahead groups, and the carry ripples from group to group.

Top module: `tc_compare`

## Requirements
- R1: With `signed_mode`=1, `lt` is 1 exactly when op_a < op_b as two's complement values. This includes a negative op_a against a positive op_b whose wrapped difference comes out positive.
- R2: With `signed_mode`=1, `gt` is 1 exactly when op_a > op_b as two's complement values. This includes a positive op_a against a negative op_b whose wrapped difference comes out negative.
- R3: `eq` is 1 exactly when the operands are bit-for-bit equal, in either mode.
- R4: With `signed_mode`=0, `lt` and `gt` follow the unsigned ordering of the operands.
- R5: For every input, exactly one of `gt`, `lt`, `eq` is 1.
- R6: With `signed_mode`=1, `sub_ovf` is 1 exactly when the true difference op_a - op_b lies outside the signed range.
- R7: With `signed_mode`=0, `sub_ovf` is 1 exactly when op_a < op_b unsigned, which is the borrow of the subtraction.
- R8: With op_a = the most negative value (only the MSB set) and op_b = 1, signed mode gives `lt`=1 and `sub_ovf`=1. Unsigned mode gives `gt`=1 and `sub_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| op_a | input | W | First operand (minuend) |
| op_b | input | W | Second operand (subtrahend) |
| gt | output | 1 | op_a is greater than op_b |
| lt | output | 1 | op_a is less than op_b |
| eq | output | 1 | Operands are equal |
| sub_ovf | output | 1 | Signed overflow (signed mode) or borrow (unsigned mode) of op_a - op_b |

## Verification
A 4-bit instance is swept over every operand pair in both modes. This reaches every sign combination, and both overflow directions at every magnitude. A 16-bit instance is driven with random pairs in both modes, which exercises the carry passing across lookahead group boundaries. Directed pairs target specific cases: the most negative value against 1, the largest positive value against the most negative, and all-ones against 1. These separate a correct overflow-corrected decision from a raw sign test, and a signed reading from an unsigned one.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Width of one carry-lookahead group in the subtractor.
    localparam int CLA_GROUP = 4;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

    // Number of lookahead groups needed to cover a given width.
    function automatic int group_count(input int width, input int grp);
        return (width + grp - 1) / grp;
    endfunction

    // Width of group k; the last group may be narrower.
    function automatic int group_width(input int width, input int grp, input int k);
        int rest;
        rest = width - k * grp;
        return (rest < grp) ? rest : grp;
    endfunction

endpackage

// File: rtl/cmp_cla_group.sv
module cmp_cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          c_i,
    output logic [GW-1:0] sum_o,
    output logic          gen_o,
    output logic          prop_o
);

    logic [GW-1:0] g;
    logic [GW-1:0] p;
    logic [GW-1:0] cbit;

    always_comb begin
        g = a_i & b_i;
        p = a_i ^ b_i;
    end

    // Every carry as a flat sum of products of generate/propagate terms.
    always_comb begin
        logic t;
        logic c;
        for (int j = 0; j < GW; j++) begin
            c = 1'b0;
            for (int k = 0; k < j; k++) begin
                t = g[k];
                for (int m = k + 1; m < j; m++) begin
                    t = t & p[m];
                end
                c = c | t;
            end
            t = c_i;
            for (int m = 0; m < j; m++) begin
                t = t & p[m];
            end
            cbit[j] = c | t;
        end
    end

    // Group generate: carry out of the top bit when no carry enters.
    always_comb begin
        logic t;
        logic c;
        c = 1'b0;
        for (int k = 0; k < GW; k++) begin
            t = g[k];
            for (int m = k + 1; m < GW; m++) begin
                t = t & p[m];
            end
            c = c | t;
        end
        gen_o  = c;
        prop_o = &p;
    end

    assign sum_o = p ^ cbit;

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i})) begin
            AST_GROUP_ADD: assert ({gen_o | (prop_o & c_i), sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{GW{1'b0}}, c_i}))
                else $error("lookahead group sum mismatch"); // R4
        end
    end

endmodule

// File: rtl/cmp_sub.sv
module cmp_sub
    import cmp_pkg::*;
#(
    parameter int W   = 16,
    parameter int GRP = CLA_GROUP
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] nb_o,
    output logic [W-1:0] diff_o,
    output logic         cout_o
);

    localparam int NGRP = group_count(W, GRP);

    logic [NGRP:0]   gc;
    logic [NGRP-1:0] gg;
    logic [NGRP-1:0] gp;

    assign nb_o  = ~b_i;
    assign gc[0] = 1'b1;          // the +1 of two's complement negation

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO = k * GRP;
        localparam int GW = group_width(W, GRP, k);
        cmp_cla_group #(.GW(GW)) u_grp (
            .a_i   (a_i[LO +: GW]),
            .b_i   (nb_o[LO +: GW]),
            .c_i   (gc[k]),
            .sum_o (diff_o[LO +: GW]),
            .gen_o (gg[k]),
            .prop_o(gp[k])
        );
        assign gc[k+1] = gg[k] | (gp[k] & gc[k]);
    end

    assign cout_o = gc[NGRP];

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_SUB_WRAP: assert ({cout_o, diff_o} ==
                ({1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1}))
                else $error("subtractor result mismatch"); // R4
        end
    end

endmodule

// File: rtl/cmp_ovf.sv
module cmp_ovf #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] nb_i,
    input  logic [W-1:0] diff_i,
    output logic         ovf_o
);

    localparam int MSB = W - 1;

    // Addition a + ~b + 1 overflows when the addends share a sign and the
    // result's sign disagrees with it.
    assign ovf_o = (a_i[MSB] == nb_i[MSB]) && (diff_i[MSB] != a_i[MSB]);

    logic [W:0] wide_diff;
    always_comb begin
        wide_diff = {a_i[MSB], a_i} - {~nb_i[MSB], ~nb_i};
        if (!$isunknown({a_i, nb_i, diff_i})) begin
            AST_NO_OVERFLOW: assert (ovf_o == (wide_diff[W] != wide_diff[W-1]))
                else $error("signed overflow flag mismatch"); // R6
        end
    end

endmodule

// File: rtl/cmp_decide.sv
module cmp_decide
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  cmp_mode_e    mode_i,
    input  logic [W-1:0] diff_i,
    input  logic         cout_i,
    input  logic         ovf_i,
    output cmp_flags_t   flags_o,
    output logic         sub_ovf_o
);

    logic zero;
    logic below;

    always_comb begin
        zero = ~|diff_i;
        unique case (mode_i)
            CMP_SIGNED:   below = diff_i[W-1] ^ ovf_i;
            CMP_UNSIGNED: below = ~cout_i;
            default:      below = 1'b0;
        endcase
        flags_o.eq = zero;
        flags_o.lt = below;
        flags_o.gt = ~below & ~zero;
        sub_ovf_o  = (mode_i == CMP_SIGNED) ? ovf_i : ~cout_i;
    end

    always_comb begin
        if (!$isunknown({mode_i, diff_i, cout_i, ovf_i})) begin
            AST_ONE_FLAG: assert ($onehot({flags_o.gt, flags_o.lt, flags_o.eq}))
                else $error("flags not one-hot"); // R5
        end
    end

endmodule

// File: rtl/tc_compare.sv
module tc_compare
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         gt,
    output logic         lt,
    output logic         eq,
    output logic         sub_ovf
);

    logic [W-1:0] nb;
    logic [W-1:0] diff;
    logic         cout;
    logic         ovf;
    cmp_flags_t   flags;
    cmp_mode_e    mode;

    assign mode = cmp_mode_e'(signed_mode);

    cmp_sub #(.W(W), .GRP(CLA_GROUP)) u_sub (
        .a_i   (op_a),
        .b_i   (op_b),
        .nb_o  (nb),
        .diff_o(diff),
        .cout_o(cout)
    );

    cmp_ovf #(.W(W)) u_ovf (
        .a_i   (op_a),
        .nb_i  (nb),
        .diff_i(diff),
        .ovf_o (ovf)
    );

    cmp_decide #(.W(W)) u_dec (
        .mode_i   (mode),
        .diff_i   (diff),
        .cout_i   (cout),
        .ovf_i    (ovf),
        .flags_o  (flags),
        .sub_ovf_o(sub_ovf)
    );

    assign gt = flags.gt;
    assign lt = flags.lt;
    assign eq = flags.eq;

    always_comb begin
        if (!$isunknown({signed_mode, op_a, op_b})) begin
            AST_SIGNED_LT: assert (!signed_mode || (lt == ($signed(op_a) < $signed(op_b))))
                else $error("signed lt wrong"); // R1
            AST_SIGNED_GT: assert (!signed_mode || (gt == ($signed(op_a) > $signed(op_b))))
                else $error("signed gt wrong"); // R2
            AST_EQUAL: assert (eq == (op_a == op_b))
                else $error("eq wrong"); // R3
            AST_UNSIGNED_LT: assert (signed_mode || (lt == (op_a < op_b)))
                else $error("unsigned lt wrong"); // R4
            AST_BORROW: assert (signed_mode || (sub_ovf == (op_a < op_b)))
                else $error("borrow flag wrong"); // R7
        end
    end

endmodule

// File: tb/sim_tc_compare.sv
`timescale 1ns/1ps
module sim_tc_compare;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        m16, m4;
    logic [15:0] a16, b16;
    logic [3:0]  a4, b4;
    logic        gt16, lt16, eq16, ov16;
    logic        gt4, lt4, eq4, ov4;

    tc_compare #(.W(16)) u0 (
        .signed_mode(m16), .op_a(a16), .op_b(b16),
        .gt(gt16), .lt(lt16), .eq(eq16), .sub_ovf(ov16)
    );

    tc_compare #(.W(4)) u4 (
        .signed_mode(m4), .op_a(a4), .op_b(b4),
        .gt(gt4), .lt(lt4), .eq(eq4), .sub_ovf(ov4)
    );

    typedef struct {
        bit         narrow;
        logic [3:0] expv;   // {gt, lt, eq, ovf}
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference from the requirements.
    function automatic logic [3:0] model(input int w, input logic [15:0] a,
                                         input logic [15:0] b, input logic m);
        longint ua, ub, sa, sb, d, span, lo, hi;
        logic g, l, e, o;
        span = longint'(1) << w;
        ua = longint'(a) & (span - 1);
        ub = longint'(b) & (span - 1);
        sa = (ua >= span / 2) ? ua - span : ua;
        sb = (ub >= span / 2) ? ub - span : ub;
        e = (ua == ub);
        if (m) begin
            l = (sa < sb);
            g = (sa > sb);
            d = sa - sb;
            lo = -(span / 2);
            hi = span / 2 - 1;
            o = (d < lo) || (d > hi);
        end else begin
            l = (ua < ub);
            g = (ua > ub);
            o = (ua < ub);
        end
        return {g, l, e, o};
    endfunction

    task automatic drive(input bit narrow, input logic [15:0] a, input logic [15:0] b,
                         input logic m, input string tag);
        item_t it;
        @(negedge clk);
        if (narrow) begin a4 = a[3:0]; b4 = b[3:0]; m4 = m; end
        else        begin a16 = a;     b16 = b;     m16 = m; end
        it.narrow = narrow;
        it.expv   = model(narrow ? 4 : 16, a, b, m);
        it.tag    = tag;
        q.push_back(it);
    endtask

    // Monitor: pops one expected item per rising edge.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it  = q.pop_front();
            act = it.narrow ? {gt4, lt4, eq4, ov4} : {gt16, lt16, eq16, ov16};
            checks++;
            if (act !== it.expv) begin
                errors++;
                $display("FAIL %s width=%0d got gt/lt/eq/ovf=%b expected %b",
                         it.tag, it.narrow ? 4 : 16, act, it.expv);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m16 = 0; a16 = 0; b16 = 0; m4 = 0; a4 = 0; b4 = 0;
        // idle state: zero operands compare equal (R3, R5)
        drive(0, 16'h0000, 16'h0000, 1'b0, "R3 R5 idle");
        drive(0, 16'h0000, 16'h0000, 1'b1, "R3 R5 idle signed");
        // R8 corner on both widths
        drive(0, 16'h8000, 16'h0001, 1'b1, "R8 signed");
        drive(0, 16'h8000, 16'h0001, 1'b0, "R8 unsigned");
        drive(1, 16'h0008, 16'h0001, 1'b1, "R8 signed narrow");
        drive(1, 16'h0008, 16'h0001, 1'b0, "R8 unsigned narrow");
        // R1 negative overflow, R2 positive overflow, R6
        drive(0, 16'h8000, 16'h7FFF, 1'b1, "R1 R6 neg wrap");
        drive(0, 16'h7FFF, 16'h8000, 1'b1, "R2 R6 pos wrap");
        drive(0, 16'h9000, 16'h7000, 1'b1, "R1 R6 neg wrap");
        drive(0, 16'h6000, 16'hA000, 1'b1, "R2 R6 pos wrap");
        // R4 R7: all-ones against one
        drive(0, 16'hFFFF, 16'h0001, 1'b0, "R4 R7 ones");
        drive(0, 16'hFFFF, 16'h0001, 1'b1, "R1 ones signed");
        drive(0, 16'h0001, 16'hFFFF, 1'b0, "R4 R7 borrow");
        drive(0, 16'h1234, 16'h1234, 1'b1, "R3 equal");
        // exhaustive narrow sweep, both modes
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    drive(1, 16'(a), 16'(b), 1'(m),
                          (m != 0) ? "R1 R2 R3 R5 R6 sweep" : "R3 R4 R5 R7 sweep");
                end
            end
        end
        // random wide pairs, both modes
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = (i % 16 == 0) ? ra : 16'($urandom);
            drive(0, ra, rb, 1'(i % 2),
                  (i % 2 != 0) ? "R1 R2 R3 R5 R6 random" : "R3 R4 R5 R7 random");
        end
        while (q.size() > 0) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule